// File: doc/BRIEF.md
# Device ROM header validator

This block checks the header of a device ROM image as the image is streamed into it one byte at a time, starting at byte 0. It rebuilds the 64-bit device identifier from bytes 1 to 8. It runs an 8-bit CRC over those identifier bytes and compares the result with the checksum in byte 0. It reads the data length from the length word at bytes 14 and 15, and from that it derives the total image size. It then runs a 32-bit Castagnoli CRC over the data region, one byte per cycle, and compares the result with the little-endian value in bytes 9 to 12.

A host pulses `start` and then presents the image bytes with `inValid`. It may leave gaps in the stream at any point. The block finishes as soon as the outcome is known. It pulses `done` for one cycle and holds the verdict, error code, identifier, size and revision warning until the next `start`. Entry parsing and fetching the bytes from storage are handled elsewhere.

Top module: `romHeaderCheck`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `done` and `pass` are low and `errCode` is 0.
- R2: A `start` pulse begins a new image at byte 0. It abandons any image in progress, and `busy` is high in the cycle after it. A byte presented in the same cycle as `start` is not consumed.
- R3: `ident` and `totalSize` read 0 after `start`. Image bytes 1 to 8 form `ident` in little-endian order, so byte 1 lands in bits 7:0 and byte 8 in bits 63:56.
- R4: The identifier CRC uses polynomial 0x07 and initial value 0xFF, and it is processed MSB first with no reflection and no final inversion. If it differs from byte 0, the block ends with errCode 2 and `totalSize` 0. `done` is high in the cycle after byte 8 is consumed.
- R5: `totalSize` is the low 10 bits of the little-endian word at bytes 14 and 15, plus 13. The upper 6 bits of byte 15 are ignored.
- R6: If the identifier is correct and the size is below 22, the block ends with errCode 1. `done` is high in the cycle after byte 15 is consumed.
- R7: The data CRC runs over bytes 13 to size-1. It is reflected CRC-32C with polynomial 0x82F63B78, initial value all ones and a final inversion. It is compared with the little-endian word in bytes 9 to 12. The block ends in the cycle after byte size-1 is consumed. A match gives `pass` high and errCode 0; a mismatch gives errCode 3.
- R8: `revWarn` is high when byte 13 is greater than 1. It does not affect `pass` or `errCode`.
- R9: A cycle with `inValid` low consumes no byte, so gaps in the stream leave the result unchanged.
- R10: `done` is a single-cycle pulse and `busy` is low while it is high. Bytes that arrive while the block is idle are ignored, and the held outputs keep their values.
- R11: The error codes are 0 for pass, 1 for too small, 2 for an identifier CRC mismatch and 3 for a data CRC mismatch. The identifier check takes priority over the size check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new image at byte 0 |
| inValid | input | 1 | `inData` carries the next image byte |
| inData | input | 8 | Image byte |
| busy | output | 1 | An image is being consumed |
| done | output | 1 | One-cycle pulse when the verdict is ready |
| pass | output | 1 | Header and data CRC both correct |
| errCode | output | 2 | 0 pass, 1 too small, 2 identifier CRC, 3 data CRC |
| revWarn | output | 1 | Revision byte above 1 |
| ident | output | 64 | Assembled device identifier |
| totalSize | output | 11 | Data length plus 13, or 0 if the length was never reached |

## Verification
A wrong byte index or a CRC register that is misaligned by one byte cannot stay hidden. It changes either the cycle in which `done` arrives or the error code that comes with it. The bench therefore expects `done` within one cycle of the last byte it predicted, and it checks all the held outputs when `done` arrives. Bytes sent after the end of an image catch a sequencer that keeps running after `done`: it would raise a second, unexpected `done` or disturb the held identifier and size within a few cycles.

// File: rtl/romHdrPkg.sv
`timescale 1ns/1ps
package romHdrPkg;

  // Byte positions inside the image header (the stream is decoded by position)
  localparam int ID_CRC_POS  = 0;
  localparam int ID_FIRST    = 1;
  localparam int ID_LAST     = 8;
  localparam int DCRC_FIRST  = 9;
  localparam int DCRC_LAST   = 12;
  localparam int REV_POS     = 13;
  localparam int LEN_LO_POS  = 14;
  localparam int LEN_HI_POS  = 15;
  localparam int DATA_START  = 13;
  localparam int HDR_BYTES   = 22;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_SMALL = 2'd1,
    ERR_ID    = 2'd2,
    ERR_DATA  = 2'd3
  } errCode_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;
    logic capIdCrc;
    logic updId;
    logic capDataCrc;
    logic capRev;
    logic updData;
    logic capLenLo;
    logic capLenHi;
  } dpStrobe_t;

  // MSB-first CRC-8 step over one byte
  function automatic logic [7:0] crc8Step(input logic [7:0] crcIn,
                                          input logic [7:0] dataIn,
                                          input logic [7:0] poly);
    logic [7:0] c;
    c = crcIn ^ dataIn;
    for (int k = 0; k < 8; k++) begin
      c = c[7] ? ((c << 1) ^ poly) : (c << 1);
    end
    return c;
  endfunction

  // Reflected CRC-32 step over one byte (poly given in reflected form)
  function automatic logic [31:0] crc32Step(input logic [31:0] crcIn,
                                            input logic [7:0]  dataIn,
                                            input logic [31:0] polyRefl);
    logic [31:0] c;
    c = crcIn ^ {24'd0, dataIn};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ polyRefl) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/romHdrDatapath.sv
`timescale 1ns/1ps
module romHdrDatapath
  import romHdrPkg::*;
#(
  parameter int          LEN_BITS   = 10,
  parameter logic [7:0]  CRC8_POLY  = 8'h07,
  parameter logic [7:0]  CRC8_INIT  = 8'hFF,
  parameter logic [31:0] CRC32_POLY = 32'h82F63B78,
  localparam int         SIZE_W     = $clog2((1 << LEN_BITS) + DATA_START),
  localparam int         ID_W       = 8 * (ID_LAST - ID_FIRST + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [7:0]        inData,
  output logic              idOk,
  output logic              dataOk,
  output logic [SIZE_W-1:0] sizeNext,
  output logic [SIZE_W-1:0] sizeQ,
  output logic [ID_W-1:0]   ident,
  output logic              revWarn
);

  localparam logic [15:0] LEN_MASK = 16'((1 << LEN_BITS) - 1);

  logic [7:0]  crc8Q;
  logic [31:0] crc32Q;
  logic [7:0]  expIdQ;
  logic [31:0] expDataQ;
  logic [7:0]  revQ;
  logic [7:0]  lenLoQ;
  logic [ID_W-1:0] identQ;

  logic [7:0]  crc8Next;
  logic [31:0] crc32Next;
  logic [15:0] lenWord;

  always_comb begin
    crc8Next  = crc8Step(crc8Q, inData, CRC8_POLY);
    crc32Next = crc32Step(crc32Q, inData, CRC32_POLY);
    lenWord   = {inData, lenLoQ};
    sizeNext  = SIZE_W'(lenWord & LEN_MASK) + SIZE_W'(DATA_START);
    idOk      = (crc8Next == expIdQ);
    dataOk    = (~crc32Next == expDataQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      crc8Q    <= CRC8_INIT;
      crc32Q   <= '1;
      expIdQ   <= '0;
      expDataQ <= '0;
      revQ     <= '0;
      lenLoQ   <= '0;
      sizeQ    <= '0;
      identQ   <= '0;
    end else begin
      if (stb.capIdCrc)   expIdQ   <= inData;
      if (stb.updId) begin
        crc8Q  <= crc8Next;
        identQ <= {inData, identQ[ID_W-1:8]};
      end
      if (stb.capDataCrc) expDataQ <= {inData, expDataQ[31:8]};
      if (stb.capRev)     revQ     <= inData;
      if (stb.updData)    crc32Q   <= crc32Next;
      if (stb.capLenLo)   lenLoQ   <= inData;
      if (stb.capLenHi)   sizeQ    <= sizeNext;
    end
  end

  assign ident   = identQ;
  assign revWarn = (revQ > 8'd1);

endmodule

// File: rtl/romHdrCtrl.sv
`timescale 1ns/1ps
module romHdrCtrl
  import romHdrPkg::*;
#(
  parameter int LEN_BITS = 10,
  localparam int SIZE_W  = $clog2((1 << LEN_BITS) + DATA_START)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              inValid,
  input  logic              idOk,
  input  logic              dataOk,
  input  logic [SIZE_W-1:0] sizeNext,
  input  logic [SIZE_W-1:0] sizeQ,
  output dpStrobe_t         stb,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [1:0]        errCode
);

  logic              busyQ;
  logic [SIZE_W-1:0] idx;
  logic              take;
  logic              finId;
  logic              finSmall;
  logic              finData;
  logic              finish;
  errCode_e          finCode;

  always_comb begin
    take = busyQ && inValid && !start;

    stb            = '0;
    stb.clear      = start;
    stb.capIdCrc   = take && (idx == SIZE_W'(ID_CRC_POS));
    stb.updId      = take && (idx >= SIZE_W'(ID_FIRST)) && (idx <= SIZE_W'(ID_LAST));
    stb.capDataCrc = take && (idx >= SIZE_W'(DCRC_FIRST)) && (idx <= SIZE_W'(DCRC_LAST));
    stb.capRev     = take && (idx == SIZE_W'(REV_POS));
    stb.updData    = take && (idx >= SIZE_W'(DATA_START));
    stb.capLenLo   = take && (idx == SIZE_W'(LEN_LO_POS));
    stb.capLenHi   = take && (idx == SIZE_W'(LEN_HI_POS));

    finId    = take && (idx == SIZE_W'(ID_LAST)) && !idOk;
    finSmall = take && (idx == SIZE_W'(LEN_HI_POS)) && (sizeNext < SIZE_W'(HDR_BYTES));
    finData  = take && (idx > SIZE_W'(LEN_HI_POS)) && (idx == sizeQ - SIZE_W'(1));
    finish   = finId || finSmall || finData;

    if (finId)         finCode = ERR_ID;
    else if (finSmall) finCode = ERR_SMALL;
    else if (dataOk)   finCode = ERR_NONE;
    else               finCode = ERR_DATA;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      idx     <= '0;
      done    <= 1'b0;
      pass    <= 1'b0;
      errCode <= ERR_NONE;
    end else begin
      done <= 1'b0;
      if (start) begin
        busyQ   <= 1'b1;
        idx     <= '0;
        pass    <= 1'b0;
        errCode <= ERR_NONE;
      end else if (take) begin
        idx <= idx + SIZE_W'(1);
        if (finish) begin
          busyQ   <= 1'b0;
          done    <= 1'b1;
          pass    <= (finCode == ERR_NONE);
          errCode <= finCode;
        end
      end
    end
  end

  assign busy = busyQ;

endmodule

// File: rtl/romHeaderCheck.sv
`timescale 1ns/1ps
module romHeaderCheck
  import romHdrPkg::*;
#(
  parameter int  LEN_BITS = 10,
  localparam int SIZE_W   = $clog2((1 << LEN_BITS) + DATA_START)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              inValid,
  input  logic [7:0]        inData,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [1:0]        errCode,
  output logic              revWarn,
  output logic [63:0]       ident,
  output logic [SIZE_W-1:0] totalSize
);

  dpStrobe_t         stb;
  logic              idOk;
  logic              dataOk;
  logic [SIZE_W-1:0] sizeNext;

  romHdrCtrl #(.LEN_BITS(LEN_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .inValid  (inValid),
    .idOk     (idOk),
    .dataOk   (dataOk),
    .sizeNext (sizeNext),
    .sizeQ    (totalSize),
    .stb      (stb),
    .busy     (busy),
    .done     (done),
    .pass     (pass),
    .errCode  (errCode)
  );

  romHdrDatapath #(.LEN_BITS(LEN_BITS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .inData   (inData),
    .idOk     (idOk),
    .dataOk   (dataOk),
    .sizeNext (sizeNext),
    .sizeQ    (totalSize),
    .ident    (ident),
    .revWarn  (revWarn)
  );

endmodule

// File: rtl/romHdrChk.sv
`timescale 1ns/1ps
module romHdrChk #(
  parameter int SIZE_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic [1:0]        errCode,
  input logic [SIZE_W-1:0] totalSize
);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (busy && !done));

  // R11
  pass_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pass == (errCode == 2'd0)));

  // R6
  small_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && errCode == 2'd1) |-> (totalSize < SIZE_W'(22)));

  // R4
  id_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && errCode == 2'd2) |-> (totalSize == '0));

  // R7
  pass_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && pass) |-> (totalSize >= SIZE_W'(22)));

endmodule

bind romHeaderCheck romHdrChk #(.SIZE_W(SIZE_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .pass      (pass),
  .errCode   (errCode),
  .totalSize (totalSize)
);

// File: tb/romHeaderCheck_tb.sv
`timescale 1ns/1ps
module romHeaderCheck_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic        inValid;
  logic [7:0]  inData;
  logic        busy, done, pass, revWarn;
  logic [1:0]  errCode;
  logic [63:0] ident;
  logic [10:0] totalSize;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [1:0]  err;
    logic        pass;
    logic [63:0] ident;
    logic [10:0] size;
    logic        warn;
  } exp_t;

  exp_t expQ[$];
  logic [7:0] img [0:1100];

  always #5 clk = ~clk;

  romHeaderCheck u_dut (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid), .inData(inData),
    .busy(busy), .done(done), .pass(pass), .errCode(errCode),
    .revWarn(revWarn), .ident(ident), .totalSize(totalSize)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [7:0] crc8Of(input int first, input int count);
    logic [7:0] v;
    v = 8'hFF;
    for (int i = 0; i < count; i++) begin
      v ^= img[first + i];
      for (int j = 0; j < 8; j++) v = v[7] ? ((v << 1) ^ 8'h07) : (v << 1);
    end
    return v;
  endfunction

  function automatic logic [31:0] crc32Of(input int first, input int count);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < count; i++) begin
      c ^= {24'd0, img[first + i]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'h82F6_3B78) : (c >> 1);
    end
    return ~c;
  endfunction

  // Monitor: pops an expected result on every done pulse
  always @(negedge clk) begin
    if (rstN === 1'b1 && done === 1'b1) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10", "unexpected done", 64'(done), 64'd0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(errCode == e.err, "R11", "errCode", 64'(errCode), 64'(e.err));
        check(pass == e.pass, "R7", "pass", 64'(pass), 64'(e.pass));
        check(ident == e.ident, "R3", "ident", ident, e.ident);
        check(totalSize == e.size, "R5", "totalSize", 64'(totalSize), 64'(e.size));
        check(revWarn == e.warn, "R8", "revWarn", 64'(revWarn), 64'(e.warn));
      end
    end
  end

  // Builds an image in img[] and returns the expected result and last byte index
  task automatic buildImage(input int len, input int hiBits, input int rev,
                            input bit badId, input bit badData, input int seed,
                            output exp_t e, output int lastIdx);
    int size;
    logic [31:0] dc;
    size = len + 13;
    for (int i = 0; i < 1100; i++) img[i] = 8'((i * 37 + seed * 11 + 5) ^ (i >> 3));
    img[13] = 8'(rev);
    img[14] = 8'(len);
    img[15] = {6'(hiBits), 2'(len >> 8)};
    img[0]  = crc8Of(1, 8) ^ (badId ? 8'h5A : 8'h00);
    if (size >= 22) begin
      dc = crc32Of(13, len);
      img[9] = dc[7:0]; img[10] = dc[15:8]; img[11] = dc[23:16]; img[12] = dc[31:24];
      if (badData) img[size - 1] ^= 8'h01;
    end
    for (int k = 1; k <= 8; k++) e.ident[8*(k-1) +: 8] = img[k];
    if (crc8Of(1, 8) != img[0]) begin
      e.err = 2'd2; e.pass = 1'b0; e.size = 11'd0; e.warn = 1'b0; lastIdx = 8;
    end else if (size < 22) begin
      e.err = 2'd1; e.pass = 1'b0; e.size = 11'(size); e.warn = (rev > 1); lastIdx = 15;
    end else begin
      dc = crc32Of(13, len);
      e.pass = (dc == {img[12], img[11], img[10], img[9]});
      e.err  = e.pass ? 2'd0 : 2'd3;
      e.size = 11'(size); e.warn = (rev > 1); lastIdx = size - 1;
    end
  endtask

  task automatic doStart(input bit junk);
    start = 1'b1; inValid = junk; inData = 8'hC3;
    tick();
    start = 1'b0; inValid = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", 64'(busy), 64'd1);
    check(ident == 64'd0 && totalSize == 11'd0, "R3", "cleared after start",
          ident ^ 64'(totalSize), 64'd0);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit gap);
    if (gap) begin inValid = 1'b0; tick(); end
    inData = b; inValid = 1'b1;
    tick();
    inValid = 1'b0;
  endtask

  task automatic runCase(input string tag, input int len, input int hiBits, input int rev,
                         input bit badId, input bit badData, input int seed,
                         input bit stall, input bit junk);
    exp_t e;
    int lastIdx;
    buildImage(len, hiBits, rev, badId, badData, seed, e, lastIdx);
    doStart(junk);
    expQ.push_back(e);
    for (int i = 0; i <= lastIdx; i++) sendByte(img[i], stall && ((i * 3 + seed) % 4 == 0));
    tick();
    check(expQ.size() == 0, tag, "done one cycle after last byte", 64'(expQ.size()), 64'd0);
    for (int i = 0; i < 3; i++) sendByte(8'hA5 ^ 8'(i), 1'b0);
    tick();
    check(ident == e.ident && totalSize == e.size && errCode == e.err && !busy,
          "R10", "held outputs after idle bytes", ident, e.ident);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; inValid = 1'b0; inData = 8'h00;
    repeat (3) tick();
    check(!busy && !done && !pass && errCode == 2'd0, "R1", "reset state",
          {59'd0, busy, done, pass, errCode}, 64'd0);
    rstN = 1'b1;
    tick();
    check(!busy && !done && !pass && errCode == 2'd0, "R1", "after reset",
          {59'd0, busy, done, pass, errCode}, 64'd0);

    // Known answer of the bench CRC-32C model (R7)
    for (int i = 0; i < 9; i++) img[i] = 8'h31 + 8'(i);
    check(crc32Of(0, 9) == 32'hE306_9283, "R7", "crc32c model", 64'(crc32Of(0, 9)), 64'hE3069283);

    runCase("R7",  9,    0,    1, 0, 0, 1, 0, 0);  // minimum size, pass
    runCase("R9",  40,   0,    2, 0, 0, 2, 1, 0);  // gaps, warning
    runCase("R4",  30,   0,    0, 1, 0, 3, 0, 0);  // identifier CRC wrong
    runCase("R6",  8,    0,    3, 0, 0, 4, 1, 0);  // too small
    runCase("R7",  25,   0,    0, 0, 1, 5, 0, 0);  // data CRC wrong
    runCase("R5",  20,   8'h2B, 1, 0, 0, 6, 0, 0); // upper length bits ignored
    runCase("R11", 5,    0,    0, 1, 0, 7, 0, 0);  // identifier error beats small

    // R2: restart in the middle of an image
    begin
      exp_t dummy;
      int li;
      buildImage(50, 0, 0, 0, 0, 8, dummy, li);
      doStart(1'b0);
      for (int i = 0; i < 20; i++) sendByte(img[i], 1'b0);
    end
    runCase("R2",  60,   0,    1, 0, 0, 9, 1, 1);
    runCase("R5",  1023, 0,    4, 0, 0, 10, 0, 0); // maximum length
    runCase("R6",  0,    0,    0, 0, 0, 11, 0, 1); // zero length, junk on start

    repeat (3) tick();
    check(expQ.size() == 0, "R10", "no pending results", 64'(expQ.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule